// File: doc/BRIEF.md
# Tamper-Monitoring Real-Time Clock

This block is a security supervisor for an always-powered domain. It keeps a seconds-and-fraction time counter, a monotonic counter that advances on software request, and a seconds alarm. A set of tamper inputs, together with the two counter-overflow events, can be armed. Any armed event moves the unit into a failure condition. Failure freezes all counting, so the time of the event is kept.

Two flags describe the condition of the unit. The non-valid flag is set whenever the battery domain is reset. The violation flag marks failure. Recovery is a fixed sequence. A system reset taken during failure adds the non-valid flag, but only if the failure hard lock is clear. Software then disarms the sources, clears the event flags, clears the violation flag and finally clears the non-valid flag. After that, a fresh seconds write restarts the clock.

Lock bits in the control register limit reconfiguration. Soft locks are removed by a system reset. Hard locks are removed only by a battery-domain reset. Every clock edge is one tick of the slow time base. The register bus is a single-cycle write strobe with a combinational read. Word addresses are 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status, 5 interrupt enable, 6 monotonic counter and 7 tamper arm.

Top module: `guard_rtc`

## Requirements
- R1: After a battery-domain reset the status word reads 1 (only the non-valid flag, bit 0). The seconds, fraction, control, monotonic and tamper-arm registers read 0, the alarm reads all ones, and irq is low.
- R2: The time counter advances one fraction step per clock only when four things hold: control bit 0 is set, the overflow flag (status bit 2) is clear, the non-valid and violation flags (status bits 0 and 1) are clear, and seconds have been written since the non-valid flag was last cleared. The fraction carries into seconds every 2^FRAC_W ticks.
- R3: An accepted write to address 0 loads the seconds and zeroes the fraction. The next tick follows one clock later.
- R4: When the whole counter wraps from all ones, it reads 0, status bit 2 is set, and the counter stays stopped until that bit is cleared.
- R5: Armed tamper pin i (tamper-arm bit i) sets event flag status bit 8+i and the violation flag in the same edge. A pin that is not armed has no effect.
- R6: While the violation flag is set, neither counter changes. The frozen time stays readable after recovery.
- R7: A status flag is cleared by writing 1 to its bit. A flag whose cause is still present stays set.
- R8: Writes are ignored in three cases: to address 7 while a tamper-configuration lock (control bit 4 soft, bit 8 hard) is set; to addresses 0 and 1 while a time lock (bit 5 soft, bit 9 hard) is set; to address 6 while a monotonic lock (bit 6 soft, bit 10 hard) is set. Each such write sets the write-error flag, status bit 5.
- R9: Lock bits are set by writing 1 and cannot be cleared by writing. Soft locks clear on a system reset. Hard locks clear only on a battery-domain reset.
- R10: A system reset during failure sets the non-valid flag when the failure hard lock (control bit 11) is clear, and leaves it clear when that lock is set.
- R11: Writing 1 to status bit 1 clears the violation flag only when three things hold: the non-valid flag is set, no event flag is set, and no armed source is active. Writing 1 to status bit 0 clears the non-valid flag only when the violation flag is clear.
- R12: The alarm flag (status bit 4) is set the clock after the seconds equal the alarm register.
- R13: irq is the OR of three terms: alarm flag AND interrupt-enable bit 0, violation flag AND bit 1, and write-error flag AND bit 2.
- R14: A write to address 6 adds one to the monotonic counter when control bit 1 is set. Wrapping sets status bit 3. When tamper-arm bit N_TAMP+1 (bit 8) is set, that flag causes failure on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow time-base clock, one tick per edge |
| rst_bat_n | input | 1 | Asynchronous active-low battery-domain reset |
| rst_sys_n | input | 1 | Synchronous active-low system reset |
| tamper_in | input | N_TAMP | Tamper detector levels (mesh, external A/B, temperature, clock, voltage, external boot) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with FRAC_W=3 and MC_W=4 and keeps the seconds at 32 bits. A seconds carry then comes every eight clocks, so the random load-and-wait checks cross many carries in a short run. Sixteen writes are enough to wrap the monotonic counter. The full time-counter wrap is reached by loading all-ones seconds and waiting eight ticks.

// File: rtl/grt_pkg.sv
package grt_pkg;

  typedef enum logic [2:0] {
    A_SECS  = 3'd0,
    A_FRAC  = 3'd1,
    A_ALARM = 3'd2,
    A_CTRL  = 3'd3,
    A_STAT  = 3'd4,
    A_IRQEN = 3'd5,
    A_MONO  = 3'd6,
    A_TAMP  = 3'd7
  } reg_addr_e;

  // control word bit positions
  localparam int C_TCE     = 0;
  localparam int C_MCE     = 1;
  localparam int C_SL_CFG  = 4;
  localparam int C_SL_TC   = 5;
  localparam int C_SL_MC   = 6;
  localparam int C_HL_CFG  = 8;
  localparam int C_HL_TC   = 9;
  localparam int C_HL_MC   = 10;
  localparam int C_HL_FAIL = 11;

  // status word bit positions
  localparam int S_NVF = 0;
  localparam int S_SVF = 1;
  localparam int S_TCO = 2;
  localparam int S_MCO = 3;
  localparam int S_CAF = 4;
  localparam int S_WEF = 5;
  localparam int S_EVT = 8;

  // sticky flag: set wins, clear request removes a flag otherwise
  function automatic logic flag_upd(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // counter step with wrap detect
  function automatic logic is_top(logic [63:0] v, int w);
    logic all;
    all = 1'b1;
    for (int i = 0; i < 64; i++) if (i < w) all &= v[i];
    return all;
  endfunction

endpackage

// File: rtl/guard_rtc_time.sv
module guard_rtc_time #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_bat_n,
  input  logic              run,
  input  logic              ld_sec,
  input  logic              ld_frac,
  input  logic              ld_alarm,
  input  logic [SEC_W-1:0]  din,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac,
  output logic [SEC_W-1:0]  alarm,
  output logic              wrap,
  output logic              alarm_hit
);
  localparam int CW = SEC_W + FRAC_W;

  logic [CW-1:0]    cnt;
  logic [SEC_W-1:0] alarm_q;
  logic             loading;

  assign loading   = ld_sec || ld_frac;
  assign sec       = cnt[CW-1:FRAC_W];
  assign frac      = cnt[FRAC_W-1:0];
  assign alarm     = alarm_q;
  assign wrap      = run && !loading && (&cnt);
  assign alarm_hit = (sec == alarm_q);

  always_ff @(posedge clk or negedge rst_bat_n) begin
    if (!rst_bat_n) begin
      cnt     <= '0;
      alarm_q <= '1;
    end else begin
      if (ld_sec)       cnt <= {din, {FRAC_W{1'b0}}};
      else if (ld_frac) cnt[FRAC_W-1:0] <= din[FRAC_W-1:0];
      else if (run)     cnt <= cnt + CW'(1);
      if (ld_alarm)     alarm_q <= din;
    end
  end

  // R2: no tick without run
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_bat_n)
    !run && !loading |=> $stable(cnt));
  // R2: exactly one tick per clock while running
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_bat_n)
    run && !loading |=> cnt == $past(cnt) + CW'(1));
  // R3: seconds load zeroes the fraction
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_bat_n)
    ld_sec |=> (frac == '0) && (sec == $past(din)));
endmodule

// File: rtl/guard_rtc_mono.sv
module guard_rtc_mono #(
  parameter int MC_W = 32
) (
  input  logic            clk,
  input  logic            rst_bat_n,
  input  logic            inc,
  output logic [MC_W-1:0] cnt,
  output logic            wrap
);
  assign wrap = inc && (&cnt);

  always_ff @(posedge clk or negedge rst_bat_n) begin
    if (!rst_bat_n)  cnt <= '0;
    else if (inc)    cnt <= cnt + MC_W'(1);
  end

  // R14: one step per accepted request, none otherwise
  p_mono_step_r14: assert property (@(posedge clk) disable iff (!rst_bat_n)
    inc |=> cnt == $past(cnt) + MC_W'(1));
  p_mono_hold_r6: assert property (@(posedge clk) disable iff (!rst_bat_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/guard_rtc_state.sv
module guard_rtc_state
  import grt_pkg::*;
#(
  parameter int N_TAMP = 7
) (
  input  logic              clk,
  input  logic              rst_bat_n,
  input  logic              rst_sys_n,
  input  logic [N_TAMP-1:0] tamper_in,
  input  logic [31:0]       wdata,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_irqen,
  input  logic              wr_tamp_ok,
  input  logic              ld_sec,
  input  logic              lock_miss,
  input  logic              tc_wrap,
  input  logic              mc_wrap,
  input  logic              alarm_hit,
  output logic [31:0]       stat_word,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       tamp_word,
  output logic [31:0]       irqen_word,
  output logic              run_tc,
  output logic              mc_live,
  output logic              tc_lock,
  output logic              mc_lock,
  output logic              cfg_lock,
  output logic              svf_o,
  output logic              wef_o,
  output logic              irq
);
  localparam int TW = N_TAMP + 2;

  logic              nvf, svf, tco, mco, caf, wef, written, tc_en, mc_en;
  logic [N_TAMP-1:0] evt, evt_cause, evt_clr;
  logic [2:0]        soft_lk, irq_en;
  logic [3:0]        hard_lk;
  logic [TW-1:0]     tamp_en;
  logic [31:0]       clr;
  logic              viol_src, svf_clear_ok, sys_to_nv;

  assign clr          = wr_stat ? wdata : '0;
  assign evt_cause    = tamper_in & tamp_en[N_TAMP-1:0];
  assign evt_clr      = clr[S_EVT +: N_TAMP];
  assign viol_src     = (|evt_cause) | (tco & tamp_en[N_TAMP]) | (mco & tamp_en[N_TAMP+1]);
  assign svf_clear_ok = nvf && !viol_src && (evt == '0);
  assign sys_to_nv    = !rst_sys_n && svf && !hard_lk[3];

  always_ff @(posedge clk or negedge rst_bat_n) begin
    if (!rst_bat_n) begin
      nvf     <= 1'b1;
      svf     <= 1'b0;
      tco     <= 1'b0;
      mco     <= 1'b0;
      caf     <= 1'b0;
      wef     <= 1'b0;
      evt     <= '0;
      written <= 1'b0;
      tc_en   <= 1'b0;
      mc_en   <= 1'b0;
      soft_lk <= '0;
      hard_lk <= '0;
      tamp_en <= '0;
      irq_en  <= '0;
    end else begin
      if (sys_to_nv)                   nvf <= 1'b1;
      else if (clr[S_NVF] && !svf)     nvf <= 1'b0;
      svf     <= flag_upd(svf, viol_src, clr[S_SVF] && svf_clear_ok);
      tco     <= flag_upd(tco, tc_wrap, clr[S_TCO]);
      mco     <= flag_upd(mco, mc_wrap, clr[S_MCO]);
      caf     <= flag_upd(caf, alarm_hit, clr[S_CAF]);
      wef     <= flag_upd(wef, lock_miss, clr[S_WEF]);
      evt     <= evt_cause | (evt & ~evt_clr);
      written <= !nvf && (written || ld_sec);
      if (wr_ctrl) begin
        tc_en   <= wdata[C_TCE];
        mc_en   <= wdata[C_MCE];
        hard_lk <= hard_lk | {wdata[C_HL_FAIL], wdata[C_HL_MC], wdata[C_HL_TC], wdata[C_HL_CFG]};
      end
      if (!rst_sys_n)   soft_lk <= '0;
      else if (wr_ctrl) soft_lk <= soft_lk | {wdata[C_SL_MC], wdata[C_SL_TC], wdata[C_SL_CFG]};
      if (wr_tamp_ok)   tamp_en <= wdata[TW-1:0];
      if (wr_irqen)     irq_en  <= wdata[2:0];
    end
  end

  assign run_tc   = tc_en && !tco && !nvf && written && !svf;
  assign mc_live  = mc_en && !svf;
  assign cfg_lock = soft_lk[0] | hard_lk[0];
  assign tc_lock  = soft_lk[1] | hard_lk[1];
  assign mc_lock  = soft_lk[2] | hard_lk[2];
  assign svf_o    = svf;
  assign wef_o    = wef;
  assign irq      = (caf & irq_en[0]) | (svf & irq_en[1]) | (wef & irq_en[2]);

  always_comb begin
    stat_word                  = '0;
    stat_word[S_NVF]           = nvf;
    stat_word[S_SVF]           = svf;
    stat_word[S_TCO]           = tco;
    stat_word[S_MCO]           = mco;
    stat_word[S_CAF]           = caf;
    stat_word[S_WEF]           = wef;
    stat_word[S_EVT +: N_TAMP] = evt;
    ctrl_word                  = '0;
    ctrl_word[C_TCE]           = tc_en;
    ctrl_word[C_MCE]           = mc_en;
    ctrl_word[C_SL_CFG]        = soft_lk[0];
    ctrl_word[C_SL_TC]         = soft_lk[1];
    ctrl_word[C_SL_MC]         = soft_lk[2];
    ctrl_word[C_HL_CFG]        = hard_lk[0];
    ctrl_word[C_HL_TC]         = hard_lk[1];
    ctrl_word[C_HL_MC]         = hard_lk[2];
    ctrl_word[C_HL_FAIL]       = hard_lk[3];
    tamp_word                  = 32'(tamp_en);
    irqen_word                 = 32'(irq_en);
  end

  // R5: failure is entered only through an armed source
  p_rise_svf_r5: assert property (@(posedge clk) disable iff (!rst_bat_n)
    $rose(svf) |-> $past(viol_src));
  // R11: non-valid leaves only outside failure
  p_nvf_exit_r11: assert property (@(posedge clk) disable iff (!rst_bat_n)
    $fell(nvf) |-> !$past(svf));
  // R11: failure leaves only from non-valid
  p_svf_exit_r11: assert property (@(posedge clk) disable iff (!rst_bat_n)
    $fell(svf) |-> $past(nvf));
  // R9: hard locks never drop while the battery domain stays up
  p_hard_sticky_r9: assert property (@(posedge clk) disable iff (!rst_bat_n)
    (hard_lk & $past(hard_lk)) == $past(hard_lk));
  // R10: system reset in unlocked failure marks the unit non-valid
  p_sys_nv_r10: assert property (@(posedge clk) disable iff (!rst_bat_n)
    sys_to_nv |=> nvf);
endmodule

// File: rtl/guard_rtc.sv
module guard_rtc
  import grt_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int MC_W   = 32,
  parameter int N_TAMP = 7
) (
  input  logic              clk,
  input  logic              rst_bat_n,
  input  logic              rst_sys_n,
  input  logic [N_TAMP-1:0] tamper_in,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  reg_addr_e          ra;
  logic               hit_secs, hit_frac, hit_alarm, hit_ctrl, hit_stat, hit_irqen, hit_mono, hit_tamp;
  logic               ld_sec, ld_frac, wr_tamp_ok, mono_inc, lock_miss;
  logic               run_tc, mc_live, tc_lock, mc_lock, cfg_lock, svf_w, wef_w;
  logic               tc_wrap, mc_wrap, alarm_hit;
  logic [SEC_W-1:0]   sec_w, alarm_w;
  logic [FRAC_W-1:0]  frac_w;
  logic [MC_W-1:0]    mono_w;
  logic [31:0]        stat_word, ctrl_word, tamp_word, irqen_word;

  assign ra        = reg_addr_e'(addr);
  assign hit_secs  = wr_en && (ra == A_SECS);
  assign hit_frac  = wr_en && (ra == A_FRAC);
  assign hit_alarm = wr_en && (ra == A_ALARM);
  assign hit_ctrl  = wr_en && (ra == A_CTRL);
  assign hit_stat  = wr_en && (ra == A_STAT);
  assign hit_irqen = wr_en && (ra == A_IRQEN);
  assign hit_mono  = wr_en && (ra == A_MONO);
  assign hit_tamp  = wr_en && (ra == A_TAMP);

  assign ld_sec     = hit_secs && !tc_lock;
  assign ld_frac    = hit_frac && !tc_lock;
  assign wr_tamp_ok = hit_tamp && !cfg_lock;
  assign mono_inc   = hit_mono && !mc_lock && mc_live;
  assign lock_miss  = ((hit_secs || hit_frac) && tc_lock) ||
                      (hit_tamp && cfg_lock) || (hit_mono && mc_lock);

  guard_rtc_time #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_time (
    .clk       (clk),
    .rst_bat_n (rst_bat_n),
    .run       (run_tc),
    .ld_sec    (ld_sec),
    .ld_frac   (ld_frac),
    .ld_alarm  (hit_alarm),
    .din       (wdata[SEC_W-1:0]),
    .sec       (sec_w),
    .frac      (frac_w),
    .alarm     (alarm_w),
    .wrap      (tc_wrap),
    .alarm_hit (alarm_hit)
  );

  guard_rtc_mono #(.MC_W(MC_W)) u_mono (
    .clk       (clk),
    .rst_bat_n (rst_bat_n),
    .inc       (mono_inc),
    .cnt       (mono_w),
    .wrap      (mc_wrap)
  );

  guard_rtc_state #(.N_TAMP(N_TAMP)) u_state (
    .clk        (clk),
    .rst_bat_n  (rst_bat_n),
    .rst_sys_n  (rst_sys_n),
    .tamper_in  (tamper_in),
    .wdata      (wdata),
    .wr_ctrl    (hit_ctrl),
    .wr_stat    (hit_stat),
    .wr_irqen   (hit_irqen),
    .wr_tamp_ok (wr_tamp_ok),
    .ld_sec     (ld_sec),
    .lock_miss  (lock_miss),
    .tc_wrap    (tc_wrap),
    .mc_wrap    (mc_wrap),
    .alarm_hit  (alarm_hit),
    .stat_word  (stat_word),
    .ctrl_word  (ctrl_word),
    .tamp_word  (tamp_word),
    .irqen_word (irqen_word),
    .run_tc     (run_tc),
    .mc_live    (mc_live),
    .tc_lock    (tc_lock),
    .mc_lock    (mc_lock),
    .cfg_lock   (cfg_lock),
    .svf_o      (svf_w),
    .wef_o      (wef_w),
    .irq        (irq)
  );

  always_comb begin
    case (ra)
      A_SECS:  rdata = 32'(sec_w);
      A_FRAC:  rdata = 32'(frac_w);
      A_ALARM: rdata = 32'(alarm_w);
      A_CTRL:  rdata = ctrl_word;
      A_STAT:  rdata = stat_word;
      A_IRQEN: rdata = irqen_word;
      A_MONO:  rdata = 32'(mono_w);
      default: rdata = tamp_word;
    endcase
  end

  // R6: failure freezes the time counter
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_bat_n)
    svf_w && !ld_sec && !ld_frac |=> $stable(sec_w) && $stable(frac_w));
  // R8: a write that a lock blocks raises the write-error flag
  p_wef_r8: assert property (@(posedge clk) disable iff (!rst_bat_n)
    lock_miss |=> wef_w);
  // R8: a blocked seconds write leaves the seconds alone or ticking
  p_locked_sec_r8: assert property (@(posedge clk) disable iff (!rst_bat_n)
    hit_secs && tc_lock && !run_tc |=> $stable(sec_w));
endmodule

// File: tb/sim_guard_rtc.sv
module sim_guard_rtc;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 3;
  localparam int MC_W   = 4;
  localparam int N_TAMP = 7;
  localparam logic [2:0] AD_SECS = 3'd0, AD_FRAC = 3'd1, AD_ALARM = 3'd2, AD_CTRL = 3'd3,
                         AD_STAT = 3'd4, AD_IRQEN = 3'd5, AD_MONO = 3'd6, AD_TAMP = 3'd7;

  logic              clk = 1'b0;
  logic              rst_bat_n = 1'b0;
  logic              rst_sys_n = 1'b1;
  logic [N_TAMP-1:0] tamper_in = '0;
  logic              wr_en = 1'b0;
  logic [2:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;
  int                n_run = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  guard_rtc #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .MC_W(MC_W), .N_TAMP(N_TAMP)) u0 (
    .clk(clk), .rst_bat_n(rst_bat_n), .rst_sys_n(rst_sys_n), .tamper_in(tamper_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] exp_sec(logic [31:0] s, int ticks);
    return s + 32'(ticks / (1 << FRAC_W));
  endfunction
  function automatic logic [31:0] exp_frac(int ticks);
    return 32'(ticks % (1 << FRAC_W));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic bat_reset();
    @(negedge clk);
    rst_bat_n = 1'b0;
    tamper_in = '0;
    idle(2);
    rst_bat_n = 1'b1;
    idle(1);
  endtask

  task automatic sys_pulse();
    @(negedge clk);
    rst_sys_n = 1'b0;
    @(negedge clk);
    rst_sys_n = 1'b1;
  endtask

  task automatic bring_up(logic [31:0] s);
    wr(AD_STAT, 32'h1);
    wr(AD_CTRL, 32'h1);
    wr(AD_SECS, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0, f0;
    void'($urandom(32'd4711));
    idle(3);
    rst_bat_n = 1'b1;
    idle(1);

    // R1 reset state
    chk_reg("R1 status", AD_STAT, 32'h1);
    chk_reg("R1 secs", AD_SECS, 32'h0);
    chk_reg("R1 frac", AD_FRAC, 32'h0);
    chk_reg("R1 alarm", AD_ALARM, 32'hFFFF_FFFF);
    chk_reg("R1 ctrl", AD_CTRL, 32'h0);
    chk_reg("R1 mono", AD_MONO, 32'h0);
    chk_reg("R1 tamper arm", AD_TAMP, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 no counting while non-valid, nor before a fresh seconds write
    wr(AD_CTRL, 32'h1);
    wr(AD_SECS, 32'd5);
    idle(20);
    chk_reg("R2 held while non-valid", AD_SECS, 32'd5);
    wr(AD_STAT, 32'h1);
    chk_reg("R11 nvf cleared", AD_STAT, 32'h0);
    idle(20);
    chk_reg("R2 held until written", AD_FRAC, 32'h0);

    // R2 R3 random loads and waits
    for (int i = 0; i < 8; i++) begin
      logic [31:0] s;
      int n;
      s = $urandom & 32'h7FFF_FFFF;
      n = 1 + int'($urandom % 60);
      wr(AD_SECS, s);
      idle(n);
      chk_reg("R2 random secs", AD_SECS, exp_sec(s, n));
      chk_reg("R3 random frac", AD_FRAC, exp_frac(n));
    end
    // R2 enable bit clear stops counting
    wr(AD_CTRL, 32'h0);
    rd(AD_SECS, s0); rd(AD_FRAC, f0);
    idle(12);
    chk_reg("R2 stopped secs", AD_SECS, s0);
    chk_reg("R2 stopped frac", AD_FRAC, f0);

    // R4 full wrap
    bat_reset();
    bring_up(32'hFFFF_FFFF);
    idle(7);
    chk_reg("R4 before wrap", AD_FRAC, 32'd7);
    idle(6);
    chk_reg("R4 wrapped secs", AD_SECS, 32'h0);
    chk_reg("R4 stays stopped", AD_FRAC, 32'h0);
    chk_reg("R4 overflow flag", AD_STAT, 32'h14);
    wr(AD_STAT, 32'h4);
    idle(3);
    chk_reg("R7 cleared overflow restarts", AD_FRAC, 32'd3);

    // R5 R6 R7 R10 R11 tamper and recovery
    bat_reset();
    bring_up(32'd100);
    wr(AD_CTRL, 32'h3);
    wr(AD_MONO, 32'h0);
    wr(AD_MONO, 32'h0);
    chk_reg("R14 mono counts writes", AD_MONO, 32'd2);
    wr(AD_TAMP, 32'h4);
    tamper_in[5] = 1'b1;
    idle(3);
    chk_reg("R5 unarmed pin ignored", AD_STAT, 32'h0);
    tamper_in[5] = 1'b0;
    tamper_in[2] = 1'b1;
    idle(1);
    chk_reg("R5 armed pin enters failure", AD_STAT, 32'h402);
    rd(AD_SECS, s0); rd(AD_FRAC, f0);
    idle(20);
    chk_reg("R6 secs frozen", AD_SECS, s0);
    chk_reg("R6 frac frozen", AD_FRAC, f0);
    wr(AD_MONO, 32'h0);
    chk_reg("R6 mono frozen", AD_MONO, 32'd2);
    wr(AD_STAT, 32'h400);
    chk_reg("R7 flag with live cause stays", AD_STAT, 32'h402);
    tamper_in[2] = 1'b0;
    wr(AD_STAT, 32'h400);
    chk_reg("R7 event flag cleared", AD_STAT, 32'h2);
    wr(AD_STAT, 32'h2);
    chk_reg("R11 violation kept while valid", AD_STAT, 32'h2);
    sys_pulse();
    chk_reg("R10 system reset adds non-valid", AD_STAT, 32'h3);
    wr(AD_STAT, 32'h1);
    chk_reg("R11 non-valid kept in failure", AD_STAT, 32'h3);
    wr(AD_TAMP, 32'h0);
    wr(AD_STAT, 32'h2);
    chk_reg("R11 violation cleared", AD_STAT, 32'h1);
    wr(AD_STAT, 32'h1);
    chk_reg("R11 unit valid", AD_STAT, 32'h0);
    chk_reg("R6 event time kept", AD_SECS, s0);
    wr(AD_SECS, 32'd200);
    idle(16);
    chk_reg("R2 restarted", AD_SECS, 32'd202);

    // R10 failure hard lock
    bat_reset();
    bring_up(32'd10);
    wr(AD_CTRL, 32'h801);
    wr(AD_TAMP, 32'h1);
    tamper_in[0] = 1'b1;
    idle(1);
    tamper_in[0] = 1'b0;
    sys_pulse();
    chk_reg("R10 hard lock keeps failure only", AD_STAT, 32'h102);
    chk_reg("R9 fail hard lock survives", AD_CTRL, 32'h801);

    // R8 R9 locks
    bat_reset();
    wr(AD_CTRL, 32'h30);
    wr(AD_TAMP, 32'h5);
    chk_reg("R8 tamper arm write ignored", AD_TAMP, 32'h0);
    chk_reg("R8 write error flag", AD_STAT, 32'h21);
    wr(AD_STAT, 32'h20);
    wr(AD_SECS, 32'd7);
    chk_reg("R8 seconds write ignored", AD_SECS, 32'h0);
    chk_reg("R8 write error again", AD_STAT, 32'h21);
    sys_pulse();
    chk_reg("R9 soft locks cleared", AD_CTRL, 32'h0);
    wr(AD_TAMP, 32'h5);
    chk_reg("R9 arm write after unlock", AD_TAMP, 32'h5);
    wr(AD_CTRL, 32'h200);
    sys_pulse();
    wr(AD_SECS, 32'd9);
    chk_reg("R9 hard time lock survives", AD_SECS, 32'h0);
    wr(AD_CTRL, 32'h42);
    wr(AD_MONO, 32'h0);
    chk_reg("R8 mono write ignored", AD_MONO, 32'h0);
    sys_pulse();
    wr(AD_MONO, 32'h0);
    chk_reg("R9 mono soft lock gone", AD_MONO, 32'h1);
    bat_reset();
    chk_reg("R9 battery reset clears hard", AD_CTRL, 32'h0);
    wr(AD_SECS, 32'd9);
    chk_reg("R9 seconds writable", AD_SECS, 32'd9);

    // R12 R13 alarm and interrupt
    bat_reset();
    bring_up(32'd50);
    wr(AD_ALARM, 32'd52);
    wr(AD_IRQEN, 32'h1);
    chk_reg("R12 no early alarm", AD_STAT, 32'h0);
    chk("R13 irq low", 32'(irq), 32'h0);
    idle(30);
    chk_reg("R12 alarm flag", AD_STAT, 32'h10);
    chk("R13 irq on alarm", 32'(irq), 32'h1);
    wr(AD_STAT, 32'h10);
    chk_reg("R7 alarm cleared", AD_STAT, 32'h0);
    chk("R13 irq drops", 32'(irq), 32'h0);
    wr(AD_CTRL, 32'h0);
    rd(AD_SECS, v);
    wr(AD_ALARM, v);
    idle(1);
    wr(AD_STAT, 32'h10);
    chk_reg("R7 alarm stays while equal", AD_STAT, 32'h10);
    wr(AD_IRQEN, 32'h0);
    chk("R13 masked", 32'(irq), 32'h0);
    wr(AD_IRQEN, 32'h2);
    chk("R13 other enable ignores alarm", 32'(irq), 32'h0);

    // R14 monotonic overflow into failure
    bat_reset();
    wr(AD_MONO, 32'h0);
    chk_reg("R14 disabled no count", AD_MONO, 32'h0);
    bring_up(32'd1);
    wr(AD_CTRL, 32'h3);
    wr(AD_TAMP, 32'h100);
    for (int i = 0; i < 15; i++) wr(AD_MONO, 32'h0);
    chk_reg("R14 mono at top", AD_MONO, 32'd15);
    chk_reg("R14 no overflow yet", AD_STAT, 32'h0);
    wr(AD_MONO, 32'h0);
    idle(1);
    chk_reg("R14 mono wrapped", AD_MONO, 32'h0);
    chk_reg("R14 overflow enters failure", AD_STAT, 32'h0A);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule